// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit timer/counter and a watchdog timer. The two share one 8-bit prescaler, and a single assignment input decides which of them it serves. The other path bypasses the prescaler. The timer counts one of two sources. The first is an instruction-cycle enable, which arrives already divided from the oscillator by 2 or by 4 outside this block. The second is an external pin: it passes through a two-flop synchronizer, and a chosen edge is then detected. The CPU can load the timer from its data bus. When the timer wraps, a one-cycle overflow interrupt pulse is raised.

The watchdog counts ticks from a free-running oscillator, which keep arriving during sleep. Its timeout base period is a parameter. When the watchdog is enabled and times out, it raises a one-cycle device-reset pulse and starts again from zero. The clear-watchdog and sleep strobes restart it. Which counters these strobes and a timer write clear depends on who owns the prescaler.

Top module: `timer_watchdog`

## Requirements
- R1: After reset, `timerVal` is 0 and `timerOvf` and `wdgReset` are both 0.
- R2: With `srcExt`=0 and the prescaler unowned by the timer (`preToWdg`=1), `timerVal` rises by 1 in each clock where `cycEn` is 1.
- R3: With `srcExt`=1, the timer counts edges of `extPin` after a two-flop synchronizer: rising edges when `edgeFall`=0 and falling edges when `edgeFall`=1. The inactive source (`cycEn` in external mode, `extPin` in internal mode) has no effect.
- R4: When `timerVal` goes from 0xFF to 0x00 on an increment, `timerOvf` is 1 for exactly that one cycle.
- R5: With `preToWdg`=0, the timer advances once per 2^(`ratioSel`+1) source events, so codes 0..7 divide by 2..256. A `timerWr` clears the prescaler.
- R6: The watchdog fires a one-cycle `wdgReset` after WDG_PERIOD counted ticks when it does not own the prescaler. When `preToWdg`=1, it fires after WDG_PERIOD·2^`ratioSel` ticks, so codes 0..7 divide by 1..128. After a timeout it restarts from zero.
- R7: `clrWdg` or `sleepCmd` restarts the watchdog count. They clear the prescaler only while `preToWdg`=1, and leave a timer-owned prescaler untouched.
- R8: While `preToWdg`=1, a `timerWr` does not clear the prescaler.
- R9: While `wdgEn`=0, the watchdog neither counts nor fires, and its count is held until it is enabled again.
- R10: A `timerWr` loads `timerWrData` into the timer. The load wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycEn | input | 1 | Instruction-cycle enable, internal timer source |
| extPin | input | 1 | External timer pin (asynchronous) |
| srcExt | input | 1 | Timer source: 0 internal, 1 external pin |
| edgeFall | input | 1 | Pin edge: 0 rising, 1 falling |
| preToWdg | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| ratioSel | input | 3 | Prescaler tap select |
| wdgEn | input | 1 | Watchdog enable |
| timerWr | input | 1 | Timer write strobe |
| timerWrData | input | 8 | Value written to the timer |
| clrWdg | input | 1 | Clear-watchdog strobe |
| sleepCmd | input | 1 | Sleep strobe |
| wdgTick | input | 1 | One-cycle tick from the watchdog oscillator |
| timerVal | output | 8 | Current timer value |
| timerOvf | output | 1 | Timer overflow interrupt pulse |
| wdgReset | output | 1 | Watchdog device-reset pulse |

## Verification
The bench builds the block with WDG_PERIOD set to 4 and the default 8-bit timer and prescaler. The short period puts every watchdog timeout within a few tens of ticks. Watchdog runs of 4 to 8 ticks therefore reach both the unprescaled and the prescaled timeout, the restart after a timeout, and the clearing by sleep and by clear-watchdog partway through a count. The full 8-bit prescaler is kept, so the largest timer ratio of 256 is reached in a run of about 300 cycles.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef struct packed {
    logic timerLoad;
    logic timerInc;
    logic wdgClr;
    logic wdgInc;
  } twStrobe_t;
endpackage

// File: rtl/tw_ctrl.sv
module tw_ctrl import tw_pkg::*; #(
  parameter int PRE_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycEn,
  input  logic               extPin,
  input  logic               srcExt,
  input  logic               edgeFall,
  input  logic               preToWdg,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               wdgEn,
  input  logic               timerWr,
  input  logic               clrWdg,
  input  logic               sleepCmd,
  input  logic               wdgTick,
  output twStrobe_t          str
);
  localparam int SYNC_N = 2;

  logic [SYNC_N:0]    pinSync;
  logic               extEvt, tmrSrcEvt, wdgSrcEvt;
  logic               preIn, preClr, tapHit, preOut, wdgClrReq;
  logic [PRE_W-1:0]   preCnt, tapMask;
  int unsigned        tapLen;

  // Synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= '0;
    else       pinSync <= {pinSync[SYNC_N-1:0], extPin};
  end

  always_comb begin
    if (edgeFall) extEvt = !pinSync[SYNC_N-1] && pinSync[SYNC_N];
    else          extEvt = pinSync[SYNC_N-1] && !pinSync[SYNC_N];
  end

  assign tmrSrcEvt = srcExt ? extEvt : cycEn;
  assign wdgSrcEvt = wdgEn && wdgTick;
  assign wdgClrReq = clrWdg || sleepCmd;
  assign preIn     = preToWdg ? wdgSrcEvt : tmrSrcEvt;
  assign preClr    = preToWdg ? wdgClrReq : timerWr;

  // Tap selection: timer ratio is one step longer than watchdog ratio
  always_comb begin
    tapLen = preToWdg ? int'(ratioSel) : int'(ratioSel) + 1;
    for (int i = 0; i < PRE_W; i++) tapMask[i] = (i < int'(tapLen));
  end

  assign tapHit = &(preCnt | ~tapMask);
  assign preOut = preIn && tapHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preCnt <= '0;
    else if (preClr) preCnt <= '0;
    else if (preIn)  preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    str.timerLoad = timerWr;
    str.timerInc  = preToWdg ? tmrSrcEvt : preOut;
    str.wdgClr    = wdgClrReq;
    str.wdgInc    = preToWdg ? preOut : wdgSrcEvt;
  end

  assert_wdg_clear_pre_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wdgClrReq && preToWdg) |=> (preCnt == '0));
  assert_write_clear_pre_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timerWr && !preToWdg) |=> (preCnt == '0));
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!wdgEn && preToWdg) |=> $stable(preCnt) || $past(wdgClrReq));
endmodule

// File: rtl/tw_data.sv
module tw_data import tw_pkg::*; #(
  parameter int TMR_W      = 8,
  parameter int WDG_PERIOD = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  twStrobe_t        str,
  input  logic [TMR_W-1:0] wrData,
  output logic [TMR_W-1:0] timerVal,
  output logic             timerOvf,
  output logic             wdgReset
);
  localparam int WDG_CW = $clog2(WDG_PERIOD + 1);
  localparam logic [WDG_CW-1:0] WDG_LAST = WDG_CW'(WDG_PERIOD - 1);

  logic [WDG_CW-1:0] wdgCnt;
  logic              wdgHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerVal <= '0;
      timerOvf <= 1'b0;
    end else begin
      timerOvf <= 1'b0;
      if (str.timerLoad) begin
        timerVal <= wrData;
      end else if (str.timerInc) begin
        timerVal <= timerVal + 1'b1;
        timerOvf <= &timerVal;
      end
    end
  end

  assign wdgHit = str.wdgInc && (wdgCnt == WDG_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdgCnt   <= '0;
      wdgReset <= 1'b0;
    end else begin
      wdgReset <= 1'b0;
      if (str.wdgClr) begin
        wdgCnt <= '0;
      end else if (wdgHit) begin
        wdgCnt   <= '0;
        wdgReset <= 1'b1;
      end else if (str.wdgInc) begin
        wdgCnt <= wdgCnt + 1'b1;
      end
    end
  end

  assert_ovf_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |-> (timerVal == '0) && ($past(timerVal) == '1));
  assert_timer_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!str.timerLoad && !str.timerInc) |=> $stable(timerVal));
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    str.timerLoad |=> (timerVal == $past(wrData)));
  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdgReset |=> !wdgReset);
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdgReset |-> (wdgCnt == '0));
endmodule

// File: rtl/timer_watchdog.sv
module timer_watchdog import tw_pkg::*; #(
  parameter int TMR_W      = 8,
  parameter int PRE_W      = 8,
  parameter int RATIO_W    = 3,
  parameter int WDG_PERIOD = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycEn,
  input  logic               extPin,
  input  logic               srcExt,
  input  logic               edgeFall,
  input  logic               preToWdg,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               wdgEn,
  input  logic               timerWr,
  input  logic [TMR_W-1:0]   timerWrData,
  input  logic               clrWdg,
  input  logic               sleepCmd,
  input  logic               wdgTick,
  output logic [TMR_W-1:0]   timerVal,
  output logic               timerOvf,
  output logic               wdgReset
);
  twStrobe_t str;

  tw_ctrl #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .extPin(extPin), .srcExt(srcExt),
    .edgeFall(edgeFall), .preToWdg(preToWdg), .ratioSel(ratioSel), .wdgEn(wdgEn),
    .timerWr(timerWr), .clrWdg(clrWdg), .sleepCmd(sleepCmd), .wdgTick(wdgTick),
    .str(str)
  );

  tw_data #(.TMR_W(TMR_W), .WDG_PERIOD(WDG_PERIOD)) u_data (
    .clk(clk), .rstN(rstN), .str(str), .wrData(timerWrData),
    .timerVal(timerVal), .timerOvf(timerOvf), .wdgReset(wdgReset)
  );
endmodule

// File: tb/timer_watchdog_bench.sv
module timer_watchdog_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycEn = 0, extPin = 0, srcExt = 0, edgeFall = 0, preToWdg = 1;
  logic [2:0] ratioSel = 0;
  logic       wdgEn = 0, timerWr = 0, clrWdg = 0, sleepCmd = 0, wdgTick = 0;
  logic [7:0] timerWrData = 0;
  logic [7:0] timerVal;
  logic       timerOvf, wdgReset;

  int testCnt = 0, failCnt = 0, ovfSeen = 0, rstSeen = 0, expRst = 0;
  bit done = 0;

  typedef struct { string req; int sel; int exp; } item_t;
  item_t expQ[$];
  event chk;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_watchdog #(.WDG_PERIOD(4)) u_timer_watchdog (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .extPin(extPin), .srcExt(srcExt),
    .edgeFall(edgeFall), .preToWdg(preToWdg), .ratioSel(ratioSel), .wdgEn(wdgEn),
    .timerWr(timerWr), .timerWrData(timerWrData), .clrWdg(clrWdg),
    .sleepCmd(sleepCmd), .wdgTick(wdgTick), .timerVal(timerVal),
    .timerOvf(timerOvf), .wdgReset(wdgReset)
  );

  always @(negedge clk) begin
    if (rstN && timerOvf) ovfSeen++;
    if (rstN && wdgReset) rstSeen++;
  end

  // Monitor: pops expected items and compares with the outputs
  initial forever begin
    item_t it;
    int act;
    @(chk);
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      case (it.sel)
        0: act = int'(timerVal);
        1: act = ovfSeen;
        default: act = rstSeen;
      endcase
      testCnt++;
      if (act != it.exp) begin
        failCnt++;
        $display("FAIL %s: actual %0d expected %0d", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_val(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
    ->chk;
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); cycEn = 1; end
    @(negedge clk); cycEn = 0;
    idle(2);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdgTick = 1;
      @(negedge clk); wdgTick = 0;
    end
    idle(2);
  endtask

  task automatic writeTimer(logic [7:0] v);
    @(negedge clk); timerWr = 1; timerWrData = v;
    @(negedge clk); timerWr = 0;
    idle(1);
  endtask

  task automatic pulseClr(bit slp);
    @(negedge clk); if (slp) sleepCmd = 1; else clrWdg = 1;
    @(negedge clk); sleepCmd = 0; clrWdg = 0;
    idle(1);
  endtask

  task automatic pinTo(logic v);
    @(negedge clk); extPin = v;
    idle(5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1;
    idle(1);
    // R1 reset state
    expect_val("R1", 0, 0);
    expect_val("R1", 1, 0);
    expect_val("R1", 2, 0);

    // R2 internal source, no prescaler
    writeTimer(8'd0);
    cycles(5);  expect_val("R2", 0, 5);
    cycles(20); expect_val("R2", 0, 25);

    // R10 load wins over increment
    @(negedge clk); timerWr = 1; timerWrData = 8'h40; cycEn = 1;
    @(negedge clk); timerWr = 0; cycEn = 0;
    idle(1); expect_val("R10", 0, 8'h40);

    // R4 wrap and single overflow pulse
    writeTimer(8'hFE);
    cycles(1); expect_val("R4", 0, 8'hFF); expect_val("R4", 1, 0);
    cycles(1); expect_val("R4", 0, 0);     expect_val("R4", 1, 1);
    cycles(1); expect_val("R4", 0, 1);     expect_val("R4", 1, 1);

    // R5 timer prescaler ratios and write clearing
    preToWdg = 0; ratioSel = 3'd2;
    writeTimer(8'd0); cycles(20);  expect_val("R5", 0, 2);
    ratioSel = 3'd0;
    writeTimer(8'd0); cycles(7);   expect_val("R5", 0, 3);
    ratioSel = 3'd7;
    writeTimer(8'd0); cycles(300); expect_val("R5", 0, 1);
    ratioSel = 3'd2;
    writeTimer(8'd0); cycles(5); writeTimer(8'd0); cycles(5);
    expect_val("R5", 0, 0);

    // R3 external pin edges
    preToWdg = 1; srcExt = 1; edgeFall = 0;
    writeTimer(8'd0);
    pinTo(1); expect_val("R3", 0, 1);
    pinTo(0); expect_val("R3", 0, 1);
    pinTo(1); expect_val("R3", 0, 2);
    edgeFall = 1; writeTimer(8'd0);
    pinTo(0); expect_val("R3", 0, 1);
    pinTo(1); expect_val("R3", 0, 1);
    cycles(10); expect_val("R3", 0, 1);
    srcExt = 0;
    pinTo(0); pinTo(1); expect_val("R3", 0, 1);

    // R6 watchdog timeout, unprescaled then prescaled
    wdgEn = 1; preToWdg = 0;
    pulseClr(0);
    ticks(3); expect_val("R6", 2, expRst);
    ticks(1); expRst++; expect_val("R6", 2, expRst);
    ticks(4); expRst++; expect_val("R6", 2, expRst);
    preToWdg = 1; ratioSel = 3'd1;
    pulseClr(0);
    ticks(7); expect_val("R6", 2, expRst);
    ticks(1); expRst++; expect_val("R6", 2, expRst);

    // R7 sleep restarts watchdog; clear leaves timer prescaler alone
    pulseClr(0); ticks(6); pulseClr(1); ticks(6);
    expect_val("R7", 2, expRst);
    ticks(2); expRst++; expect_val("R7", 2, expRst);
    preToWdg = 0; ratioSel = 3'd0;
    writeTimer(8'd0); cycles(1); pulseClr(0); cycles(1);
    expect_val("R7", 0, 1);

    // R8 timer write keeps watchdog prescaler
    preToWdg = 1; ratioSel = 3'd1;
    pulseClr(0); ticks(1); writeTimer(8'd9); ticks(7);
    expRst++; expect_val("R8", 2, expRst);

    // R9 disabled watchdog holds count
    preToWdg = 0;
    pulseClr(0); ticks(2);
    wdgEn = 0; ticks(10); expect_val("R9", 2, expRst);
    wdgEn = 1; ticks(1);  expect_val("R9", 2, expRst);
    ticks(1); expRst++;   expect_val("R9", 2, expRst);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule